// File: doc/BRIEF.md
# Low-Power Entry and Wake Controller

This block decides when a processor core is put into a low-power state and when it is brought back out. The core signals wait-for-interrupt and wait-for-event instructions as one-cycle requests. It also signals a return from an exception handler to thread code. The controller answers with a request for either ordinary sleep or deep sleep, and later with a one-clock wake pulse. Interrupt controllers supply per-line pending and enable vectors, and software can raise an event pulse directly.

A small control register holds three settings. The first re-enters sleep automatically when a handler returns to thread code. The second picks deep sleep over ordinary sleep. The third lets any newly pending interrupt count as an event, whether or not that line is enabled. A one-bit event latch remembers an event that arrives while the core is not waiting for one. The next wait-for-event then completes at once instead of sleeping.

Top module: `lpw_ctrl`

## Requirements
- R1: After reset, sleep_req, deep_req, wake and evt_pending are 0 and cfg_rdata reads 0.
- R2: The control register stores cfg_wdata bit 1 (sleep-on-exit), bit 2 (deep select) and bit 4 (event-on-any-pending) when cfg_we is 1; every other bit reads back 0 whatever was written.
- R3: A sleep entry drives sleep_req alone when deep select is 0 and deep_req alone when deep select is 1; sleep_req, deep_req and wake are never high together.
- R4: A wait-for-interrupt sleep ends only when some line is both pending and enabled; a set event latch, a software event pulse and a disabled pending line (even with event-on-any-pending set) leave it asleep.
- R5: A wait-for-event sleep ends on a software event pulse or on an enabled line that becomes pending.
- R6: With event-on-any-pending at 0, a disabled line that becomes pending does not end a wait-for-event sleep; with it at 1, it does.
- R7: An event that occurs while the core is not in a wait-for-event sleep sets evt_pending; the next wait-for-event request then gives a wake pulse on the following cycle with no sleep request and clears evt_pending.
- R8: wake is high for exactly one clock, and sleep_req or deep_req falls in the same cycle that wake rises.
- R9: Events come from 0-to-1 edges of irq_pend; a line that stays pending raises only one event.
- R10: With sleep-on-exit at 1, exc_ret_thread enters sleep (ordinary or deep per deep select) and wakes as a wait-for-interrupt; with it at 0, exc_ret_thread has no effect.
- R11: A register write and an event in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| exc_ret_thread | input | 1 | Exception return to thread code pulse |
| irq_pend | input | NUM_IRQ | Per-line interrupt pending |
| irq_en | input | NUM_IRQ | Per-line interrupt enable |
| sev_pulse | input | 1 | Software event pulse |
| sleep_req | output | 1 | Ordinary sleep request |
| deep_req | output | 1 | Deep sleep request |
| wake | output | 1 | One-clock wake pulse |
| evt_pending | output | 1 | Latched event register |

## Verification
A stale or wrongly set event latch shows up on the first wait-for-event after it. That request either returns a wake pulse one cycle later with no sleep request, or it sleeps when it should not. A wrong sleep state or a lost deep-select capture is visible on sleep_req and deep_req on the cycle after the request. A wake condition decoded against the wrong sleep kind shows up one cycle after the offending pending edge or software pulse, as a missing or spurious wake pulse. A broken edge detector appears as a second immediate completion while a line is held pending.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int CFG_W    = 32;
  localparam int SOE_BIT  = 1;
  localparam int DEEP_BIT = 2;
  localparam int SEOP_BIT = 4;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_WFI = 2'd1,
    ST_WFE = 2'd2
  } lpw_state_e;

  typedef struct packed {
    logic seop;
    logic deep;
    logic soe;
  } lpw_cfg_t;
endpackage

// File: rtl/lpw_cfg_reg.sv
module lpw_cfg_reg
  import lpw_pkg::*;
#(
  parameter int DW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output lpw_cfg_t      cfg,
  output logic [DW-1:0] rdata
);
  lpw_cfg_t cfg_q, cfg_d;
  logic     wdata_unused;

  assign wdata_unused = ^wdata;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.soe  = wdata[SOE_BIT];
      cfg_d.deep = wdata[DEEP_BIT];
      cfg_d.seop = wdata[SEOP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata           = '0;
    rdata[SOE_BIT]  = cfg_q.soe;
    rdata[DEEP_BIT] = cfg_q.deep;
    rdata[SEOP_BIT] = cfg_q.seop;
  end

  assign cfg = cfg_q;

  a_r2_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[DEEP_BIT] == $past(wdata[DEEP_BIT])));
endmodule

// File: rtl/lpw_evt_unit.sv
module lpw_evt_unit #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_pend,
  input  logic [N-1:0] irq_en,
  input  logic         sev,
  input  logic         seop,
  input  logic         consume,
  output logic         evt_now,
  output logic         evt_q,
  output logic         irq_lvl
);
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;
  logic [N-1:0] qual;
  logic         evt_d;

  assign rise = irq_pend & ~pend_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign qual[i] = rise[i] & (irq_en[i] | seop);
  end

  assign evt_now = sev | (|qual);
  assign irq_lvl = |(irq_pend & irq_en);

  always_comb begin
    evt_d = evt_q;
    if (consume)      evt_d = 1'b0;
    else if (evt_now) evt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      pend_q <= irq_pend;
      evt_q  <= evt_d;
    end
  end

  a_r9_latch_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(evt_now));
endmodule

// File: rtl/lpw_sleep_fsm.sv
module lpw_sleep_fsm
  import lpw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wfi_req,
  input  logic     wfe_req,
  input  logic     exc_ret,
  input  lpw_cfg_t cfg,
  input  logic     evt_now,
  input  logic     evt_q,
  input  logic     irq_lvl,
  output logic     consume,
  output logic     sleep_req,
  output logic     deep_req,
  output logic     wake
);
  lpw_state_e st_q, st_d;
  logic       dsel_q, dsel_d;
  logic       wake_q, wake_d;

  always_comb begin
    st_d    = st_q;
    dsel_d  = dsel_q;
    wake_d  = 1'b0;
    consume = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (wfi_req || (exc_ret && cfg.soe)) begin
          if (irq_lvl) wake_d = 1'b1;
          else begin
            st_d   = ST_WFI;
            dsel_d = cfg.deep;
          end
        end else if (wfe_req) begin
          if (evt_q || evt_now || irq_lvl) begin
            wake_d  = 1'b1;
            consume = 1'b1;
          end else begin
            st_d   = ST_WFE;
            dsel_d = cfg.deep;
          end
        end
      end
      ST_WFI: begin
        if (irq_lvl) begin
          st_d   = ST_RUN;
          wake_d = 1'b1;
        end
      end
      ST_WFE: begin
        if (irq_lvl || evt_now) begin
          st_d    = ST_RUN;
          wake_d  = 1'b1;
          consume = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      dsel_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dsel_q <= dsel_d;
      wake_q <= wake_d;
    end
  end

  assign sleep_req = (st_q != ST_RUN) & ~dsel_q;
  assign deep_req  = (st_q != ST_RUN) &  dsel_q;
  assign wake      = wake_q;

  a_r3_one_output: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sleep_req, deep_req, wake}));

  a_r8_fall_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req || deep_req) |-> wake);

  a_r4_wfi_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WFI && !irq_lvl) |=> !wake);

  a_r5_wfe_sev_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WFE && evt_now) |=> (wake && !sleep_req && !deep_req));
endmodule

// File: rtl/lpw_ctrl.sv
module lpw_ctrl
  import lpw_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               wfi_req,
  input  logic               wfe_req,
  input  logic               exc_ret_thread,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               sev_pulse,
  output logic               sleep_req,
  output logic               deep_req,
  output logic               wake,
  output logic               evt_pending
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  lpw_cfg_t   cfg;
  logic       evt_now, evt_q, irq_lvl, consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  lpw_cfg_reg #(.DW(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  lpw_evt_unit #(.N(NUM_IRQ)) u_evt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .sev      (sev_pulse),
    .seop     (cfg.seop),
    .consume  (consume),
    .evt_now  (evt_now),
    .evt_q    (evt_q),
    .irq_lvl  (irq_lvl)
  );

  lpw_sleep_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wfi_req   (wfi_req),
    .wfe_req   (wfe_req),
    .exc_ret   (exc_ret_thread),
    .cfg       (cfg),
    .evt_now   (evt_now),
    .evt_q     (evt_q),
    .irq_lvl   (irq_lvl),
    .consume   (consume),
    .sleep_req (sleep_req),
    .deep_req  (deep_req),
    .wake      (wake)
  );

  assign evt_pending = evt_q;

  a_r7_latch_used: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sleep_req && !deep_req && !wake && wfe_req && !wfi_req && evt_pending)
      |=> (wake && !evt_pending && !sleep_req && !deep_req));
endmodule

// File: tb/tb_lpw_ctrl.sv
module tb_lpw_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          wfi_req, wfe_req, exc_ret_thread, sev_pulse;
  logic [N-1:0]  irq_pend, irq_en;
  logic          sleep_req, deep_req, wake, evt_pending;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpw_ctrl #(.NUM_IRQ(N)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .exc_ret_thread(exc_ret_thread), .irq_pend(irq_pend), .irq_en(irq_en),
    .sev_pulse(sev_pulse), .sleep_req(sleep_req), .deep_req(deep_req),
    .wake(wake), .evt_pending(evt_pending)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // outputs packed as {sleep_req, deep_req, wake, evt_pending}
  function automatic logic [31:0] outs();
    return {28'd0, sleep_req, deep_req, wake, evt_pending};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    cyc();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic pulse_wfi();
    wfi_req = 1'b1; cyc(); wfi_req = 1'b0;
  endtask

  task automatic pulse_wfe();
    wfe_req = 1'b1; cyc(); wfe_req = 1'b0;
  endtask

  task automatic pulse_sev();
    sev_pulse = 1'b1; cyc(); sev_pulse = 1'b0;
  endtask

  task automatic clean();
    irq_pend = '0; irq_en = '0;
    cyc();
    if (evt_pending) begin
      pulse_wfe();
      cyc();
    end
    wr(32'h0);
  endtask

  task automatic t_reset();
    chk("R1 outputs", outs(), 32'h0);
    chk("R1 rdata", cfg_rdata, 32'h0);
  endtask

  task automatic t_reg();
    wr(32'hFFFF_FFFF);
    chk("R2 all ones", cfg_rdata, 32'h16);
    wr(32'h0000_0004);
    chk("R2 deep only", cfg_rdata, 32'h04);
    wr(32'h0);
    chk("R2 clear", cfg_rdata, 32'h0);
  endtask

  task automatic t_wfi_modes();
    pulse_wfi();
    chk("R3 ordinary sleep", outs(), 32'b1000);
    irq_en[0] = 1'b1; irq_pend[0] = 1'b1;
    cyc();
    chk("R8 wake with sleep drop", outs(), 32'b0011);
    cyc();
    chk("R8 wake one clock", outs(), 32'b0001);
    clean();
    wr(32'h4);
    pulse_wfi();
    chk("R3 deep sleep", outs(), 32'b0100);
    irq_en[5] = 1'b1; irq_pend[5] = 1'b1;
    cyc();
    chk("R8 deep drops with wake", outs(), 32'b0011);
    clean();
  endtask

  task automatic t_wfi_ignore();
    wr(32'h10);
    pulse_sev();
    chk("R7 sev latched", outs(), 32'b0001);
    pulse_wfi();
    chk("R4 wfi sleeps despite latch", outs(), 32'b1001);
    pulse_sev();
    chk("R4 sev ignored", outs(), 32'b1001);
    irq_pend[2] = 1'b1;
    cyc(); cyc();
    chk("R4 disabled pend ignored", outs(), 32'b1001);
    irq_en[6] = 1'b1; irq_pend[6] = 1'b1;
    cyc();
    chk("R4 enabled pend wakes", outs(), 32'b0011);
    clean();
  endtask

  task automatic t_wfe_sev();
    pulse_wfe();
    chk("R5 wfe sleeps", outs(), 32'b1000);
    pulse_sev();
    chk("R5 sev wakes", outs(), 32'b0010);
    cyc();
    pulse_wfe();
    chk("R5 wfe sleeps again", outs(), 32'b1000);
    irq_en[1] = 1'b1; irq_pend[1] = 1'b1;
    cyc();
    chk("R5 enabled pend wakes", outs(), 32'b0010);
    clean();
  endtask

  task automatic t_seop();
    pulse_wfe();
    irq_pend[3] = 1'b1;
    cyc(); cyc();
    chk("R6 disabled pend no wake", outs(), 32'b1000);
    irq_pend[3] = 1'b0;
    wr(32'h10);
    chk("R6 still asleep", outs(), 32'b1000);
    irq_pend[3] = 1'b1;
    cyc();
    chk("R6 any pend wakes", outs(), 32'b0010);
    clean();
  endtask

  task automatic t_latch();
    pulse_sev();
    chk("R7 latch set", evt_pending, 1'b1);
    pulse_wfe();
    chk("R7 immediate wake, latch cleared", outs(), 32'b0010);
    cyc();
    chk("R7 no sleep after", outs(), 32'b0000);
    clean();
  endtask

  task automatic t_edge();
    wr(32'h10);
    irq_pend[7] = 1'b1;
    cyc();
    chk("R9 first edge latched", evt_pending, 1'b1);
    pulse_wfe();
    chk("R9 consumed", outs(), 32'b0010);
    cyc();
    pulse_wfe();
    chk("R9 held line no event", outs(), 32'b1000);
    pulse_sev();
    chk("R9 sev wakes", outs(), 32'b0010);
    clean();
  endtask

  task automatic t_exit();
    wr(32'h6);
    exc_ret_thread = 1'b1; cyc(); exc_ret_thread = 1'b0;
    chk("R10 exit deep sleep", outs(), 32'b0100);
    pulse_sev();
    chk("R10 sev ignored", outs(), 32'b0101);
    irq_en[4] = 1'b1; irq_pend[4] = 1'b1;
    cyc();
    chk("R10 irq wakes", outs(), 32'b0011);
    clean();
    wr(32'h2);
    exc_ret_thread = 1'b1; cyc(); exc_ret_thread = 1'b0;
    chk("R10 exit ordinary sleep", outs(), 32'b1000);
    irq_en[0] = 1'b1; irq_pend[0] = 1'b1;
    cyc();
    clean();
    exc_ret_thread = 1'b1; cyc(); exc_ret_thread = 1'b0;
    chk("R10 soe off no effect", outs(), 32'b0000);
  endtask

  task automatic t_same_cycle();
    cfg_we = 1'b1; cfg_wdata = 32'h4; sev_pulse = 1'b1;
    cyc();
    cfg_we = 1'b0; cfg_wdata = '0; sev_pulse = 1'b0;
    chk("R11 write kept", cfg_rdata, 32'h4);
    chk("R11 event kept", evt_pending, 1'b1);
    clean();
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    wfi_req = 1'b0; wfe_req = 1'b0; exc_ret_thread = 1'b0; sev_pulse = 1'b0;
    irq_pend = '0; irq_en = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_reg();
    t_wfi_modes();
    t_wfi_ignore();
    t_wfe_sev();
    t_seop();
    t_latch();
    t_edge();
    t_exit();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule